// File: doc/BRIEF.md
# Flag-Generating Adder-Subtractor Unit

This block adds or subtracts two integer operands of a parameterised width and returns the result with four status flags: carry, zero, sign and overflow. Subtraction takes one pass through the same ripple-carry adder used for addition. The second operand is inverted bit by bit, and the extra one is fed into the least significant stage as the adder's carry-in. Because the two's complement of the subtrahend is never formed as a separate step, the overflow flag stays correct when the subtrahend is the most negative value, which is its own complement.

A chain carry input allows multi-word add-with-carry and subtract-with-borrow. A mode pin sets the meaning of the carry flag and of the chain input for subtraction. In carry mode, both keep the raw adder polarity: 1 means no borrow. In borrow mode, both are inverted: 1 means a borrow. Addition always uses the raw carry.

Operands enter on a valid/ready handshake. An operation is accepted on a rising edge where `in_valid` and `in_ready` are both high. `in_ready` is high when the output register is empty or is being drained in the same cycle. The result sits in an output register. It is offered with `out_valid` and stays unchanged while `out_ready` is low. The mode and operation pins are sampled with the operands, and synchronous reset clears every output.

Top module: `addsub_flag_unit`

## Requirements
- R1: With `op_sub`=1, the result equals `op_a` + (bitwise NOT `op_b`) + k modulo 2^W, computed in one addition, where k is the adder carry-in given in R5. With `op_sub`=0, the result equals `op_a` + `op_b` + k modulo 2^W.
- R2: `flag_v` is the XOR of the carry into the most significant bit and the carry out of it, both taken from that single addition. Subtracting the most negative value (1 followed by zeros) from a non-negative operand therefore sets `flag_v`. For example, at W=4 with k=1, 0001 − 1000 gives 1001 with `flag_v`=1.
- R3: For subtraction, `flag_c` is the raw adder carry-out when `borrow_mode`=0 and its inverse (a borrow) when `borrow_mode`=1.
- R4: For addition, `flag_c` is the raw adder carry-out, whatever `borrow_mode` is.
- R5: The adder carry-in k equals `chain_in`, except in a subtraction with `borrow_mode`=1, where k equals NOT `chain_in`.
- R6: `flag_z` is 1 exactly when every result bit is 0. `flag_s` equals the result's most significant bit.
- R7: While `rst` is high at a rising edge, `result`, all four flags and `out_valid` become 0 and inputs are ignored.
- R8: `in_ready` = NOT `out_valid` OR `out_ready`. An accepted operation appears on the outputs with `out_valid`=1 after the next rising edge. If nothing is accepted while the output drains or is empty, `out_valid` becomes 0.
- R9: While `out_valid`=1 and `out_ready`=0, `result`, the flags and `out_valid` hold their values, even if `in_valid` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operand set is offered |
| in_ready | output | 1 | Unit can take an operand set this cycle |
| op_a | input | W | First operand |
| op_b | input | W | Second operand (subtrahend for subtraction) |
| op_sub | input | 1 | 1 = subtract, 0 = add |
| chain_in | input | 1 | Incoming carry, or borrow in borrow mode for subtraction |
| borrow_mode | input | 1 | 1 = carry flag and chain input use borrow polarity for subtraction |
| out_valid | output | 1 | Result register holds an unconsumed result |
| out_ready | input | 1 | Downstream takes the result this cycle |
| result | output | W | Sum or difference |
| flag_c | output | 1 | Carry, or borrow per R3 |
| flag_z | output | 1 | Result is zero |
| flag_s | output | 1 | Sign (result MSB) |
| flag_v | output | 1 | Signed overflow |

## Verification
The bench builds the unit with W=4. At that width, all 256 operand pairs can be run for both operations, both carry modes and both chain-input values, and the results are compared with an integer-arithmetic model that never inverts bits. The narrow width also makes the most negative operand (1000) and the extreme sums easy to hit on purpose. Seeded random operations with random downstream stalls then exercise the handshake, holding and draining of the output register.

// File: rtl/addsub_pkg.sv
package addsub_pkg;
  typedef struct packed {
    logic c;
    logic z;
    logic s;
    logic v;
  } addsub_flags_t;
endpackage

// File: rtl/addsub_operand_cond.sv
module addsub_operand_cond #(
  parameter int W = 8
) (
  input  logic [W-1:0] b_in,
  input  logic         sub,
  input  logic         chain,
  input  logic         borrow_mode,
  output logic [W-1:0] b_eff,
  output logic         adder_cin
);
  // Invert the subtrahend in place; the +1 enters through the carry-in.
  assign b_eff     = sub ? ~b_in : b_in;
  // In borrow mode a subtraction's chain input is a borrow (R5).
  assign adder_cin = (sub && borrow_mode) ? ~chain : chain;
endmodule

// File: rtl/addsub_ripple_core.sv
module addsub_ripple_core #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         c_into_msb,
  output logic         c_out
);
  logic [W:0] chain_c;

  assign chain_c[0] = cin;

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign sum[i]       = a[i] ^ b[i] ^ chain_c[i];
    assign chain_c[i+1] = (a[i] & b[i]) | (a[i] & chain_c[i]) | (b[i] & chain_c[i]);
  end

  assign c_into_msb = chain_c[W-1];
  assign c_out      = chain_c[W];

  // R1: the bit-level chain must match a wide arithmetic sum of the same inputs.
  always_comb begin
    if (!$isunknown({a, b, cin})) begin
      assert_chain_sum_R1: assert ({c_out, sum} == ({1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin}))
        else $error("ripple chain disagrees with arithmetic sum");
    end
  end
endmodule

// File: rtl/addsub_flag_gen.sv
module addsub_flag_gen
  import addsub_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0]  sum,
  input  logic          c_into_msb,
  input  logic          c_out,
  input  logic          sub,
  input  logic          borrow_mode,
  output addsub_flags_t flags
);
  always_comb begin
    flags.c = (sub && borrow_mode) ? ~c_out : c_out;
    flags.z = ~|sum;
    flags.s = sum[W-1];
    flags.v = c_into_msb ^ c_out;
  end
endmodule

// File: rtl/addsub_flag_unit.sv
module addsub_flag_unit
  import addsub_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  input  logic         op_sub,
  input  logic         chain_in,
  input  logic         borrow_mode,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] result,
  output logic         flag_c,
  output logic         flag_z,
  output logic         flag_s,
  output logic         flag_v
);
  localparam int MSB = W - 1;

  logic [W-1:0]  b_eff;
  logic          adder_cin;
  logic [W-1:0]  sum_w;
  logic          c_msb_w;
  logic          c_out_w;
  addsub_flags_t flags_w;

  logic [W-1:0]  res_q;
  addsub_flags_t flags_q;
  logic          valid_q;
  logic          take;

  addsub_operand_cond #(.W(W)) u_cond (
    .b_in        (op_b),
    .sub         (op_sub),
    .chain       (chain_in),
    .borrow_mode (borrow_mode),
    .b_eff       (b_eff),
    .adder_cin   (adder_cin)
  );

  addsub_ripple_core #(.W(W)) u_core (
    .a          (op_a),
    .b          (b_eff),
    .cin        (adder_cin),
    .sum        (sum_w),
    .c_into_msb (c_msb_w),
    .c_out      (c_out_w)
  );

  addsub_flag_gen #(.W(W)) u_flags (
    .sum         (sum_w),
    .c_into_msb  (c_msb_w),
    .c_out       (c_out_w),
    .sub         (op_sub),
    .borrow_mode (borrow_mode),
    .flags       (flags_w)
  );

  assign in_ready = ~valid_q | out_ready;
  assign take     = in_valid & in_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      res_q   <= '0;
      flags_q <= '0;
      valid_q <= 1'b0;
    end else if (take) begin
      res_q   <= sum_w;
      flags_q <= flags_w;
      valid_q <= 1'b1;
    end else if (out_ready) begin
      valid_q <= 1'b0;
    end
  end

  assign out_valid = valid_q;
  assign result    = res_q;
  assign flag_c    = flags_q.c;
  assign flag_z    = flags_q.z;
  assign flag_s    = flags_q.s;
  assign flag_v    = flags_q.v;

  assert_reset_clear_R7: assert property (@(posedge clk)
    rst |=> (!out_valid && result == '0 && !flag_c && !flag_z && !flag_s && !flag_v))
    else $error("reset did not clear outputs");

  assert_accept_R8: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> out_valid)
    else $error("accepted operation not presented");

  assert_drain_R8: assert property (@(posedge clk) disable iff (rst)
    (!in_valid && (out_ready || !out_valid)) |=> !out_valid)
    else $error("output stayed valid after drain");

  assert_stall_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(result) && $stable(flag_c)
                                   && $stable(flag_z) && $stable(flag_s) && $stable(flag_v)))
    else $error("output changed during stall");

  assert_zero_sign_R6: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (flag_z == (result == '0) && flag_s == result[MSB]))
    else $error("zero or sign flag inconsistent with result");
endmodule

// File: tb/sim_addsub_flag_unit.sv
module sim_addsub_flag_unit;
  localparam int W = 4;
  localparam int N = 1 << W;
  localparam int HALF = 1 << (W - 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [W-1:0] op_a = '0;
  logic [W-1:0] op_b = '0;
  logic op_sub = 1'b0;
  logic chain_in = 1'b0;
  logic borrow_mode = 1'b0;
  logic out_valid;
  logic out_ready = 1'b1;
  logic [W-1:0] result;
  logic flag_c, flag_z, flag_s, flag_v;

  int n_checks = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  addsub_flag_unit #(.W(W)) u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .op_a(op_a), .op_b(op_b), .op_sub(op_sub), .chain_in(chain_in),
    .borrow_mode(borrow_mode), .out_valid(out_valid), .out_ready(out_ready),
    .result(result), .flag_c(flag_c), .flag_z(flag_z), .flag_s(flag_s), .flag_v(flag_v)
  );

  // Integer model: {valid, result, c, z, s, v}
  function automatic logic [W+4:0] model(int a, int b, bit sub, bit bmode, bit chain);
    int sa, sb, raw, sr, bin;
    bit c, v;
    logic [W-1:0] r;
    sa = (a >= HALF) ? a - N : a;
    sb = (b >= HALF) ? b - N : b;
    if (!sub) begin
      raw = a + b + int'(chain);
      c = (raw >= N);
      sr = sa + sb + int'(chain);
    end else begin
      bin = bmode ? int'(chain) : 1 - int'(chain);
      raw = a - b - bin;
      c = bmode ? (raw < 0) : (raw >= 0);
      sr = sa - sb - bin;
    end
    r = W'(raw & (N - 1));
    v = (sr > HALF - 1) || (sr < -HALF);
    return {1'b1, r, c, (r == '0), r[W-1], v};
  endfunction

  function automatic logic [W+4:0] observed();
    return {out_valid, result, flag_c, flag_z, flag_s, flag_v};
  endfunction

  task automatic check(string tag, logic [W+4:0] got, logic [W+4:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got v=%b r=%b czsv=%b expected v=%b r=%b czsv=%b",
               tag, got[W+4], got[W+3:4], got[3:0], exp[W+4], exp[W+3:4], exp[3:0]);
    end
  endtask

  task automatic check_bit(string tag, logic got, logic exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b", tag, got, exp);
    end
  endtask

  // Drive at a falling edge; the result is registered at the next rising edge
  // and sampled at the following falling edge.
  task automatic run_op(string tag, int a, int b, bit sub, bit bmode, bit chain);
    op_a = W'(a); op_b = W'(b); op_sub = sub; borrow_mode = bmode; chain_in = chain;
    in_valid = 1'b1;
    @(negedge clk);
    check(tag, observed(), model(a, b, sub, bmode, chain));
  endtask

  initial begin
    #(100000 * 10);
    n_fail++;
    $display("FAIL watchdog: run did not complete");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

  initial begin
    logic [W+4:0] held;
    void'($urandom(32'h5eed_1234));

    // R7: reset clears everything, even with an operand offered
    op_a = 4'hF; op_b = 4'hF; in_valid = 1'b1;
    @(negedge clk); @(negedge clk);
    check("R7 reset clear", observed(), '0);
    rst = 1'b0;

    // R2: most negative subtrahend, plain subtraction in both modes
    run_op("R2 0001-1000 carry mode", 1, 8, 1, 0, 1);
    check_bit("R2 overflow set", flag_v, 1'b1);
    run_op("R2 0001-1000 borrow mode", 1, 8, 1, 1, 0);
    check_bit("R2 result 1001", result == 4'b1001, 1'b1);
    run_op("R2 0000-1000", 0, 8, 1, 0, 1);

    // R3 / R4: carry polarity
    run_op("R3 3-5 borrow mode", 3, 5, 1, 1, 0);
    check_bit("R3 borrow flag", flag_c, 1'b1);
    run_op("R3 3-5 carry mode", 3, 5, 1, 0, 1);
    check_bit("R3 raw carry", flag_c, 1'b0);
    run_op("R4 F+1 borrow mode", 15, 1, 0, 1, 0);
    check_bit("R4 add carry", flag_c, 1'b1);

    // R5: chain input feeds carry-in
    run_op("R5 add with carry 7+0+1", 7, 0, 0, 0, 1);
    run_op("R5 sub with borrow 5-2-1", 5, 2, 1, 1, 1);
    run_op("R5 sub carry mode chain0 5-2-1", 5, 2, 1, 0, 0);

    // R6: zero and sign
    run_op("R6 zero 6-6", 6, 6, 1, 1, 0);
    check_bit("R6 zero flag", flag_z, 1'b1);
    run_op("R6 sign 2-6", 2, 6, 1, 1, 0);
    check_bit("R6 sign flag", flag_s, 1'b1);

    // R1 with R3, R4, R5, R2, R6: exhaustive sweep at W=4
    for (int a = 0; a < N; a++)
      for (int b = 0; b < N; b++)
        for (int k = 0; k < 8; k++)
          run_op("R1 exhaustive", a, b, k[0], k[1], k[2]);

    // R8 / R9: stall and drain
    run_op("R8 before stall", 9, 4, 0, 0, 0);
    held = observed();
    out_ready = 1'b0;
    op_a = 4'h1; op_b = 4'h1; op_sub = 1'b0; chain_in = 1'b0; borrow_mode = 1'b0;
    #1;
    check_bit("R8 in_ready low while stalled", in_ready, 1'b0);
    @(negedge clk);
    check("R9 hold during stall", observed(), held);
    @(negedge clk);
    check("R9 hold second cycle", observed(), held);
    out_ready = 1'b1;
    #1;
    check_bit("R8 in_ready back high", in_ready, 1'b1);
    @(negedge clk);
    check("R8 accepted after stall", observed(), model(1, 1, 0, 0, 0));
    in_valid = 1'b0;
    @(negedge clk);
    check_bit("R8 drains to invalid", out_valid, 1'b0);

    // Random stream with random downstream stalls (R1, R8, R9)
    for (int i = 0; i < 400; i++) begin
      int a, b;
      bit sub, bm, ch;
      logic [W+4:0] exp;
      a = int'($urandom_range(N - 1)); b = int'($urandom_range(N - 1));
      sub = 1'($urandom); bm = 1'($urandom); ch = 1'($urandom);
      exp = model(a, b, sub, bm, ch);
      op_a = W'(a); op_b = W'(b); op_sub = sub; borrow_mode = bm; chain_in = ch;
      in_valid = 1'b1; out_ready = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      out_ready = 1'($urandom);
      @(negedge clk);
      if (!out_ready) check("R9 random stall hold", observed(), exp);
      else check_bit("R8 random drain", out_valid, 1'b0);
      out_ready = 1'b1;
      @(negedge clk);
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end
endmodule